// File: doc/BRIEF.md
# ISA DMA to PCI Memory Bridge

This block sits between the ISA-side DMA channels of an integrated south bridge and a PCI bus master port. It watches the DMA request lines and asks the PCI arbiter for the bus on behalf of the winning channel. Only after the grant arrives does it acknowledge that channel. From then on, every DMA memory strobe from the DMA controller becomes one PCI memory transaction with a single data phase: a memory read strobe fetches data from PCI memory for the ISA I/O device, and a memory write strobe stores the device's data into PCI memory.

While the PCI transaction is in flight, the block pulls the ISA ready line low, so the ISA DMA cycle cannot finish before the data has crossed. Channels 0 to 3 carry one byte per cycle. Channels 5 to 7 carry one 16-bit word per cycle. Channel 4 has no request input and is never served. All DMA memory accesses target PCI memory. The ISA strobes and request lines are taken to be already synchronous to the PCI clock.

The controller has six states. ST_IDLE: no bus request. ST_BUSREQ: the bus is requested for the latched channel. ST_OWNED: the bus is granted and the channel is acknowledged. ST_ADDR: the PCI address phase, with FRAME# low. ST_DATA: the PCI data phase, with IRDY# low. ST_DONE: the handshake is complete and ISA ready is released.

The transitions are:
- ST_IDLE to ST_BUSREQ when any usable request is present.
- ST_BUSREQ to ST_OWNED when the grant is sampled low.
- ST_BUSREQ or ST_OWNED back to ST_IDLE when the selected request drops.
- ST_OWNED to ST_ADDR when a strobe is seen while granted.
- ST_ADDR to ST_DATA unconditionally.
- ST_DATA to ST_DONE when TRDY# is sampled low.
- ST_DONE to ST_OWNED once both strobes are released.

Top module: `isadma_pci_bridge`

## Requirements
- R1: Among the request inputs 0-3 and 5-7, the lowest-numbered active one is selected. Request bit 4 is ignored and, on its own, never produces a bus request or an acknowledge.
- R2: The selected channel is held until its acknowledge is released, even if a lower-numbered request rises meanwhile.
- R3: The PCI bus request (active low) goes low one clock after a usable request is sampled. The acknowledges (active low, one per channel) stay high until the grant is sampled low. At most one acknowledge is ever low, and only while the bus request is low.
- R4: When the selected request is sampled low with no PCI transaction in progress, the bus request and the acknowledge both return high on the next clock. A request that falls during a transaction keeps the bus request low until that transaction has ended.
- R5: A transaction starts only while the grant is low. The address phase drives FRAME# low, AD = address with bits 1:0 forced to zero, and C/BE# = 0110 for a memory read strobe or 0111 for a memory write strobe.
- R6: FRAME# is high in every clock where IRDY# is low, so each transaction has exactly one data phase that directly follows the address phase. IRDY# returns high in the clock after TRDY# is sampled low.
- R7: The ISA ready output is low from the address phase through the clock in which TRDY# is sampled low, and high at all other times, including after reset.
- R8: The data-phase C/BE# (active-low byte enables) selects lanes as follows. For a 16-bit channel, address bit 1 = 0 gives 1100 and address bit 1 = 1 gives 0011. For an 8-bit channel, only bit n is low, where n = address bits 1:0.
- R9: On a write, the ISA data is placed on AD during the data phase. A 16-bit channel uses AD[15:0] when address bit 1 = 0 and AD[31:16] when it is 1. An 8-bit channel uses ISA data bits 7:0 placed at AD[8n+7:8n]. All other AD bits are zero.
- R10: On a read, the lane chosen by the R8 rule is captured in the TRDY# clock and returned on the ISA read data: the 16-bit lane for a wide channel, or the byte zero-extended into bits 7:0 for a narrow channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| dreq | input | NUM_CH | DMA request lines, bit 4 unused |
| dack_n | output | NUM_CH | Active-low DMA acknowledges |
| memr_n | input | 1 | DMA memory read strobe, active low |
| memw_n | input | 1 | DMA memory write strobe, active low |
| dma_addr | input | ADDR_W | Memory address from the DMA controller |
| isa_wdata | input | SD_W | Data from the ISA device for PCI writes |
| isa_rdata | output | SD_W | Data returned from PCI reads |
| io_rdy | output | 1 | ISA channel ready, low stretches the cycle |
| pci_req_n | output | 1 | Bus request to the PCI arbiter |
| pci_gnt_n | input | 1 | Bus grant from the PCI arbiter |
| pci_frame_n | output | 1 | PCI FRAME# |
| pci_irdy_n | output | 1 | PCI IRDY# |
| pci_trdy_n | input | 1 | PCI TRDY# from the target |
| pci_ad_out | output | AD_W | Address/data driven onto AD |
| pci_ad_oe | output | 1 | Output enable for AD |
| pci_ad_in | input | AD_W | Address/data sampled from AD |
| pci_cbe_n | output | AD_W/8 | Command / byte enables |

## Verification
The hardest situation to reach is a request line that falls while a PCI transaction is still waiting for TRDY#. The bus request must then stay low until the transaction ends, and drop only after the strobe is released. The bench drives this case by dropping the request right after the address phase, while the modelled target holds off TRDY# for several wait states. A second hard case is a lower-numbered request rising while another channel holds the acknowledge. The bench raises channel 0 during the channel 2 grant and then confirms that the acknowledge hands over only after a full release.

// File: rtl/isadma_pkg.sv
package isadma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSREQ,
        ST_OWNED,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } brg_state_t;

    localparam logic [3:0] CMD_MEM_READ  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/isadma_prio.sv
module isadma_prio #(
    parameter int NUM_CH    = 8,
    parameter int ABSENT_CH = 4,
    localparam int IDX_W    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    logic [NUM_CH-1:0] usable;

    // channel without a request pin is masked out
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
            if (g == ABSENT_CH) begin : g_gap
                assign usable[g] = req[g] & 1'b0;
            end else begin : g_live
                assign usable[g] = req[g];
            end
        end
    endgenerate

    // scan from the top so the lowest index wins
    always_comb begin
        any = |usable;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (usable[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/isadma_lane_pack.sv
module isadma_lane_pack #(
    parameter int AD_W  = 32,
    parameter int SD_W  = 16,
    localparam int NBE  = AD_W / 8,
    localparam int HALF = NBE / 2
) (
    input  logic            wide,
    input  logic [1:0]      lane_sel,
    input  logic [SD_W-1:0] wdat,
    output logic [NBE-1:0]  be_n,
    output logic [AD_W-1:0] word
);

    always_comb begin
        be_n = '1;
        word = '0;
        if (wide) begin
            for (int b = 0; b < NBE; b++) begin
                if ((b >= HALF) == lane_sel[1]) be_n[b] = 1'b0;
            end
            word[(lane_sel[1] ? AD_W / 2 : 0) +: SD_W] = wdat;
        end else begin
            be_n[lane_sel] = 1'b0;
            word[{lane_sel, 3'b000} +: 8] = wdat[7:0];
        end
    end

endmodule

// File: rtl/isadma_lane_unpack.sv
module isadma_lane_unpack #(
    parameter int AD_W = 32,
    parameter int SD_W = 16
) (
    input  logic            wide,
    input  logic [1:0]      lane_sel,
    input  logic [AD_W-1:0] word,
    output logic [SD_W-1:0] rdat
);

    always_comb begin
        if (wide) begin
            rdat = word[(lane_sel[1] ? AD_W / 2 : 0) +: SD_W];
        end else begin
            rdat = SD_W'(word[{lane_sel, 3'b000} +: 8]);
        end
    end

endmodule

// File: rtl/isadma_pci_bridge.sv
module isadma_pci_bridge
    import isadma_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int ABSENT_CH = 4,
    parameter int WIDE_FROM = 5,
    parameter int ADDR_W    = 24,
    parameter int AD_W      = 32,
    parameter int SD_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dreq,
    output logic [NUM_CH-1:0] dack_n,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [SD_W-1:0]   isa_wdata,
    output logic [SD_W-1:0]   isa_rdata,
    output logic              io_rdy,
    output logic              pci_req_n,
    input  logic              pci_gnt_n,
    output logic              pci_frame_n,
    output logic              pci_irdy_n,
    input  logic              pci_trdy_n,
    output logic [AD_W-1:0]   pci_ad_out,
    output logic              pci_ad_oe,
    input  logic [AD_W-1:0]   pci_ad_in,
    output logic [AD_W/8-1:0] pci_cbe_n
);

    localparam int IDX_W = $clog2(NUM_CH);
    localparam int NBE   = AD_W / 8;

    brg_state_t state_q, state_d;

    logic [IDX_W-1:0]  sel_q;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SD_W-1:0]   wdat_q;
    logic [SD_W-1:0]   rdat_q;
    logic [SD_W-1:0]   rdat_lane;
    logic [NBE-1:0]    be_n;
    logic [AD_W-1:0]   wr_word;
    logic              sel_wide;
    logic              sel_req;
    logic              strobe;

    assign sel_wide = (sel_q >= IDX_W'(WIDE_FROM));
    assign sel_req  = dreq[sel_q];
    assign strobe   = !memr_n || !memw_n;

    isadma_prio #(
        .NUM_CH    (NUM_CH),
        .ABSENT_CH (ABSENT_CH)
    ) i_prio (
        .req (dreq),
        .any (pick_any),
        .idx (pick_idx)
    );

    isadma_lane_pack #(
        .AD_W (AD_W),
        .SD_W (SD_W)
    ) i_pack (
        .wide     (sel_wide),
        .lane_sel (addr_q[1:0]),
        .wdat     (wdat_q),
        .be_n     (be_n),
        .word     (wr_word)
    );

    isadma_lane_unpack #(
        .AD_W (AD_W),
        .SD_W (SD_W)
    ) i_unpack (
        .wide     (sel_wide),
        .lane_sel (addr_q[1:0]),
        .word     (pci_ad_in),
        .rdat     (rdat_lane)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pick_any) state_d = ST_BUSREQ;
            ST_BUSREQ: begin
                if (!sel_req)        state_d = ST_IDLE;
                else if (!pci_gnt_n) state_d = ST_OWNED;
            end
            ST_OWNED: begin
                if (!sel_req)                  state_d = ST_IDLE;
                else if (!pci_gnt_n && strobe) state_d = ST_ADDR;
            end
            ST_ADDR:   state_d = ST_DATA;
            ST_DATA:   if (!pci_trdy_n) state_d = ST_DONE;
            ST_DONE:   if (!strobe) state_d = ST_OWNED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // channel, address and data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (state_q == ST_IDLE && pick_any) sel_q <= pick_idx;
            if (state_q == ST_OWNED && state_d == ST_ADDR) begin
                addr_q <= dma_addr;
                wdat_q <= isa_wdata;
                rd_q   <= !memr_n;
            end
            if (state_q == ST_DATA && !pci_trdy_n && rd_q) rdat_q <= rdat_lane;
        end
    end

    assign isa_rdata = rdat_q;

    // outputs decoded from the state
    always_comb begin
        dack_n      = '1;
        pci_req_n   = 1'b1;
        pci_frame_n = 1'b1;
        pci_irdy_n  = 1'b1;
        io_rdy      = 1'b1;
        pci_ad_out  = '0;
        pci_ad_oe   = 1'b0;
        pci_cbe_n   = '1;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSREQ: pci_req_n = 1'b0;
            ST_OWNED: begin
                pci_req_n     = 1'b0;
                dack_n[sel_q] = 1'b0;
            end
            ST_ADDR: begin
                pci_req_n     = 1'b0;
                dack_n[sel_q] = 1'b0;
                pci_frame_n   = 1'b0;
                io_rdy        = 1'b0;
                pci_ad_out    = AD_W'({addr_q[ADDR_W-1:2], 2'b00});
                pci_ad_oe     = 1'b1;
                pci_cbe_n     = rd_q ? CMD_MEM_READ : CMD_MEM_WRITE;
            end
            ST_DATA: begin
                pci_req_n     = 1'b0;
                dack_n[sel_q] = 1'b0;
                pci_irdy_n    = 1'b0;
                io_rdy        = 1'b0;
                pci_cbe_n     = be_n;
                if (!rd_q) begin
                    pci_ad_out = wr_word;
                    pci_ad_oe  = 1'b1;
                end
            end
            ST_DONE: begin
                pci_req_n     = 1'b0;
                dack_n[sel_q] = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/isadma_pci_bridge_chk.sv
module isadma_pci_bridge_chk #(
    parameter int NUM_CH    = 8,
    parameter int ABSENT_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] dack_n,
    input logic              pci_req_n,
    input logic              pci_gnt_n,
    input logic              pci_frame_n,
    input logic              pci_irdy_n,
    input logic              pci_trdy_n,
    input logic              io_rdy
);

    // R1
    gap_channel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_n[ABSENT_CH]);

    // R3
    single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dack_n));

    // R3
    ack_under_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_n != '1) |-> !pci_req_n);

    // R5
    start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_frame_n) |-> $past(!pci_gnt_n));

    // R6
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_irdy_n |-> pci_frame_n);

    // R6
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_frame_n |=> !pci_irdy_n);

    // R6
    handshake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_irdy_n && !pci_trdy_n) |=> (pci_irdy_n && io_rdy));

    // R7
    ready_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_frame_n || !pci_irdy_n) |-> !io_rdy);

    // R7
    ready_low_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rdy |-> (!pci_frame_n || !pci_irdy_n));

endmodule

bind isadma_pci_bridge isadma_pci_bridge_chk #(
    .NUM_CH    (NUM_CH),
    .ABSENT_CH (ABSENT_CH)
) i_chk (.*);

// File: tb/test_isadma_pci_bridge.sv
`timescale 1ns/1ps
module test_isadma_pci_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dreq = '0;
    logic [7:0]  dack_n;
    logic        memr_n = 1'b1;
    logic        memw_n = 1'b1;
    logic [23:0] dma_addr = '0;
    logic [15:0] isa_wdata = '0;
    logic [15:0] isa_rdata;
    logic        io_rdy;
    logic        pci_req_n;
    logic        pci_gnt_n = 1'b1;
    logic        pci_frame_n;
    logic        pci_irdy_n;
    logic        pci_trdy_n = 1'b1;
    logic [31:0] pci_ad_out;
    logic        pci_ad_oe;
    logic [31:0] pci_ad_in = '0;
    logic [3:0]  pci_cbe_n;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  gnt_hold = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  be_n;
        logic [31:0] wword;
        bit          is_wr;
        logic [31:0] rword;
        int          waits;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    isadma_pci_bridge i_isadma_pci_bridge (
        .clk, .rst_n, .dreq, .dack_n, .memr_n, .memw_n, .dma_addr,
        .isa_wdata, .isa_rdata, .io_rdy, .pci_req_n, .pci_gnt_n,
        .pci_frame_n, .pci_irdy_n, .pci_trdy_n, .pci_ad_out, .pci_ad_oe,
        .pci_ad_in, .pci_cbe_n
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // simple arbiter: grant follows request unless held off
    always @(negedge clk) pci_gnt_n = pci_req_n || gnt_hold;

    // monitor and PCI target model
    exp_t cur;
    bit   in_dp = 1'b0;
    int   wcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pci_frame_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected address phase", pci_ad_out, 32'h0);
                end else begin
                    chk(pci_cbe_n == exp_q[0].cmd, "R5", "command", 32'(pci_cbe_n), 32'(exp_q[0].cmd));
                    chk(pci_ad_out == exp_q[0].addr, "R5", "address", pci_ad_out, exp_q[0].addr);
                end
            end
            if (!pci_irdy_n) begin
                if (!in_dp) begin
                    in_dp = 1'b1;
                    wcnt = 0;
                    if (exp_q.size() != 0) cur = exp_q.pop_front();
                    chk(pci_cbe_n == cur.be_n, "R8", "byte enables", 32'(pci_cbe_n), 32'(cur.be_n));
                    if (cur.is_wr)
                        chk(pci_ad_out == cur.wword, "R9", "write lane", pci_ad_out, cur.wword);
                    pci_ad_in = cur.rword;
                end
                chk(pci_frame_n == 1'b1, "R6", "frame in data phase", 32'(pci_frame_n), 32'h1);
                chk(io_rdy == 1'b0, "R7", "ready stretched", 32'(io_rdy), 32'h0);
                if (wcnt == cur.waits) pci_trdy_n = 1'b0;
                else wcnt++;
            end else begin
                if (in_dp) begin
                    chk(io_rdy == 1'b1, "R7", "ready after handshake", 32'(io_rdy), 32'h1);
                    chk(pci_irdy_n == 1'b1, "R6", "irdy released", 32'(pci_irdy_n), 32'h1);
                end
                in_dp = 1'b0;
                pci_trdy_n = 1'b1;
            end
        end
    end

    // driver: one DMA cycle on channel ch
    task automatic xfer(input int ch, input logic [23:0] a, input bit rd,
                        input logic [15:0] wd, input logic [31:0] rw,
                        input int waits, input bit drop_early);
        exp_t e;
        bit wide;
        logic [15:0] rexp;
        wide = (ch >= 5);
        e.cmd = rd ? 4'b0110 : 4'b0111;
        e.addr = {8'h00, a[23:2], 2'b00};
        e.is_wr = !rd;
        e.rword = rw;
        e.waits = waits;
        if (wide) begin
            e.be_n  = a[1] ? 4'b0011 : 4'b1100;
            e.wword = a[1] ? {wd, 16'h0000} : {16'h0000, wd};
            rexp    = a[1] ? rw[31:16] : rw[15:0];
        end else begin
            e.be_n  = ~(4'b0001 << a[1:0]);
            e.wword = {24'h0, wd[7:0]} << (8 * a[1:0]);
            rexp    = {8'h00, rw[8 * a[1:0] +: 8]};
        end
        exp_q.push_back(e);
        @(negedge clk);
        dreq[ch] = 1'b1;
        while (dack_n[ch] !== 1'b0) @(negedge clk);
        chk(dack_n == ~(8'b1 << ch), "R3", "acknowledge vector", 32'(dack_n), 32'(~(8'b1 << ch)));
        dma_addr  = a;
        isa_wdata = wd;
        if (rd) memr_n = 1'b0; else memw_n = 1'b0;
        @(negedge clk);
        chk(io_rdy == 1'b0, "R7", "ready low at address phase", 32'(io_rdy), 32'h0);
        if (drop_early) dreq[ch] = 1'b0;
        while (io_rdy !== 1'b1) begin
            if (drop_early)
                chk(pci_req_n == 1'b0, "R4", "request held during cycle", 32'(pci_req_n), 32'h0);
            @(negedge clk);
        end
        if (rd) chk(isa_rdata == rexp, "R10", "read data", 32'(isa_rdata), 32'(rexp));
        memr_n = 1'b1;
        memw_n = 1'b1;
        @(negedge clk);
        if (drop_early) begin
            @(negedge clk);
            chk(pci_req_n == 1'b1 && dack_n == 8'hFF, "R4", "release after cycle",
                {23'h0, pci_req_n, dack_n}, 32'h1FF);
        end
    endtask

    task automatic release_ch(input int ch);
        dreq[ch] = 1'b0;
        @(negedge clk);
        chk(pci_req_n == 1'b1 && dack_n == 8'hFF, "R4", "release one clock after drop",
            {23'h0, pci_req_n, dack_n}, 32'h1FF);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pci_req_n == 1'b1 && dack_n == 8'hFF, "R3", "reset idle", {23'h0, pci_req_n, dack_n}, 32'h1FF);
        chk(io_rdy == 1'b1 && pci_frame_n && pci_irdy_n, "R7", "reset ready/frame/irdy",
            {29'h0, io_rdy, pci_frame_n, pci_irdy_n}, 32'h7);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: request bit 4 alone does nothing
        dreq = 8'h10;
        repeat (4) @(negedge clk);
        chk(pci_req_n == 1'b1 && dack_n == 8'hFF, "R1", "bit 4 ignored", {23'h0, pci_req_n, dack_n}, 32'h1FF);
        dreq = 8'h00;
        @(negedge clk);

        // R3: acknowledge waits for grant
        gnt_hold = 1'b1;
        dreq[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk(pci_req_n == 1'b0, "R3", "bus requested", 32'(pci_req_n), 32'h0);
        chk(dack_n == 8'hFF, "R3", "no ack before grant", 32'(dack_n), 32'hFF);
        gnt_hold = 1'b0;

        // narrow channel: write lane 2, read lane 1
        xfer(1, 24'h00_1236, 1'b0, 16'h99A5, 32'h0, 2, 1'b0);
        xfer(1, 24'h00_2001, 1'b1, 16'h0, 32'hA1B2C3D4, 0, 1'b0);
        release_ch(1);

        // wide channel: write low lane, read high lane
        xfer(6, 24'h03_4560, 1'b0, 16'hBEEF, 32'h0, 1, 1'b0);
        xfer(6, 24'h03_4562, 1'b1, 16'h0, 32'h12345678, 3, 1'b0);
        release_ch(6);

        // R4: request drops while target inserts waits
        xfer(3, 24'h00_0F03, 1'b0, 16'h005A, 32'h0, 4, 1'b1);

        // wide read low lane, narrow write lane 0
        xfer(7, 24'h7F_FFF0, 1'b1, 16'h0, 32'hCAFEF00D, 0, 1'b0);
        release_ch(7);
        xfer(0, 24'h00_0104, 1'b0, 16'h1177, 32'h0, 1, 1'b0);
        release_ch(0);

        // R1/R2: fixed priority and hold
        dreq = 8'b1010_0100;
        while (dack_n == 8'hFF) @(negedge clk);
        chk(dack_n == 8'hFB, "R1", "lowest channel wins", 32'(dack_n), 32'hFB);
        dreq[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(dack_n == 8'hFB, "R2", "selection held", 32'(dack_n), 32'hFB);
        release_ch(2);
        while (dack_n == 8'hFF) @(negedge clk);
        chk(dack_n == 8'hFE, "R1", "next lowest after release", 32'(dack_n), 32'hFE);
        dreq = 8'h00;
        @(negedge clk);
        chk(pci_req_n == 1'b1, "R4", "all released", 32'(pci_req_n), 32'h1);

        // R4: request withdrawn before grant
        gnt_hold = 1'b1;
        dreq[5] = 1'b1;
        while (pci_req_n) @(negedge clk);
        dreq[5] = 1'b0;
        @(negedge clk);
        chk(pci_req_n == 1'b1 && dack_n == 8'hFF, "R4", "withdrawn before grant",
            {23'h0, pci_req_n, dack_n}, 32'h1FF);
        gnt_hold = 1'b0;

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "all transactions seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule